// File: doc/BRIEF.md
# Multi-Slot Branch Winner Resolver

This block sits after the decode of one wide instruction and decides which single control transfer, if any, the instruction takes. Each issue slot that can carry a branch or return hands the block a valid flag, a kind bit (conditional or unconditional), a predicate and a precomputed target address. The block resolves them in one combinational pass and registers the result: a taken flag, the index of the winning slot and its target. It also flags an instruction whose encoding places an unconditional transfer anywhere other than slot zero.

Evaluation runs from the highest-numbered slot down to slot zero. The first slot that fires ends the evaluation, and no slot after it can win, whatever its predicate. Because an unconditional transfer always fires, it is only meaningful as the last one evaluated, so it is legal only in slot zero. Slot zero therefore acts as the fallback when no higher slot fires. Branches and returns resolve identically; the kind bit is the only thing that matters. The number of slots and the address width are parameters.

Top module: `branch_winner`

## Requirements
- R1: While rst_ni is low, taken_o, win_slot_o, tgt_o and illegal_o are all zero.
- R2: A valid slot with slot_uncond_i bit = 0 (conditional) and slot_pred_i bit = 0 does not fire and cannot be the winner.
- R3: A valid slot fires when its slot_uncond_i bit is 1 (unconditional) or its slot_pred_i bit is 1. The winner's target, taken from bits [k*ADDR_W +: ADDR_W] of slot_tgt_i for slot k, appears on tgt_o with taken_o high.
- R4: Among firing slots, the highest-numbered one wins. Every firing slot with a lower number is ignored, even one with a true predicate.
- R5: Slot zero is evaluated last. An unconditional transfer in slot zero wins only when no higher slot fires.
- R6: illegal_o is high when any valid slot numbered 1 or above has its slot_uncond_i bit set. The winner is still chosen by the same order.
- R7: A slot whose slot_vld_i bit is 0 is ignored, whatever its kind, predicate and target.
- R8: When no slot fires, taken_o is low, and win_slot_o and tgt_o are zero (the instruction falls through).
- R9: Every output reflects the slot inputs present at the previous rising clock edge: exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| slot_vld_i | input | NUM_SLOTS | Slot holds a branch or return |
| slot_uncond_i | input | NUM_SLOTS | 1 = unconditional, 0 = conditional |
| slot_pred_i | input | NUM_SLOTS | Predicate of a conditional slot |
| slot_tgt_i | input | NUM_SLOTS*ADDR_W | Per-slot target; slot k in bits [k*ADDR_W +: ADDR_W] |
| taken_o | output | 1 | A transfer is taken |
| win_slot_o | output | IDX_W | Index of the winning slot, 0 when none |
| tgt_o | output | ADDR_W | Target of the winner, 0 when none |
| illegal_o | output | 1 | Unconditional transfer found outside slot zero |

## Verification
Every result (taken flag, winning index, target and illegal flag) is due exactly one rising edge after the slot inputs that produce it. Inputs change only on falling edges. The driver computes the expected result with a model that walks the slots from the top index down, and it queues that result when it applies the stimulus. The monitor wakes one time unit after each rising edge and compares the head of the queue. An item is therefore always checked against the edge that captured its own inputs, never against a neighbour's.

// File: rtl/brw_pkg.sv
package brw_pkg;

  typedef enum logic {
    KIND_COND   = 1'b0,
    KIND_UNCOND = 1'b1
  } xfer_kind_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/brw_slot_eval.sv
module brw_slot_eval #(
  parameter int SLOT_IDX = 0
) (
  input  logic vld_i,
  input  logic uncond_i,
  input  logic pred_i,
  output logic fire_o,
  output logic bad_o
);
  import brw_pkg::*;

  xfer_kind_e kind;
  assign kind = xfer_kind_e'(uncond_i);

  assign fire_o = vld_i & ((kind == KIND_UNCOND) | pred_i);

  generate
    if (SLOT_IDX == 0) begin : g_slot0
      assign bad_o = 1'b0;
    end else begin : g_upper
      // unconditional above slot zero is an encoding error
      assign bad_o = vld_i & (kind == KIND_UNCOND);
    end
  endgenerate

endmodule

// File: rtl/brw_priority.sv
module brw_priority #(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 2
) (
  input  logic [NUM_SLOTS-1:0]        fire_i,
  input  logic [NUM_SLOTS*ADDR_W-1:0] tgt_i,
  output logic                        taken_o,
  output logic [IDX_W-1:0]            idx_o,
  output logic [ADDR_W-1:0]           tgt_o
);

  logic [NUM_SLOTS:0]   hit_above;
  logic [NUM_SLOTS-1:0] sel;

  assign hit_above[NUM_SLOTS] = 1'b0;

  // highest slot first: a slot is chosen only if nothing above fired
  generate
    for (genvar i = NUM_SLOTS - 1; i >= 0; i--) begin : g_chain
      assign hit_above[i] = hit_above[i+1] | fire_i[i];
      assign sel[i]       = fire_i[i] & ~hit_above[i+1];
    end
  endgenerate

  assign taken_o = hit_above[0];

  always_comb begin
    idx_o = '0;
    tgt_o = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (sel[i]) begin
        idx_o = IDX_W'(i);
        tgt_o = tgt_i[i*ADDR_W +: ADDR_W];
      end
    end
  end

endmodule

// File: rtl/branch_winner.sv
module branch_winner #(
  parameter int NUM_SLOTS = 4,
  parameter int ADDR_W    = 32,
  localparam int IDX_W    = brw_pkg::idx_width(NUM_SLOTS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_SLOTS-1:0]        slot_vld_i,
  input  logic [NUM_SLOTS-1:0]        slot_uncond_i,
  input  logic [NUM_SLOTS-1:0]        slot_pred_i,
  input  logic [NUM_SLOTS*ADDR_W-1:0] slot_tgt_i,
  output logic                        taken_o,
  output logic [IDX_W-1:0]            win_slot_o,
  output logic [ADDR_W-1:0]           tgt_o,
  output logic                        illegal_o
);

  logic [NUM_SLOTS-1:0] fire;
  logic [NUM_SLOTS-1:0] bad;
  logic                 taken_d;
  logic [IDX_W-1:0]     idx_d;
  logic [ADDR_W-1:0]    tgt_d;

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      brw_slot_eval #(.SLOT_IDX(s)) u_eval (
        .vld_i    (slot_vld_i[s]),
        .uncond_i (slot_uncond_i[s]),
        .pred_i   (slot_pred_i[s]),
        .fire_o   (fire[s]),
        .bad_o    (bad[s])
      );
    end
  endgenerate

  brw_priority #(
    .NUM_SLOTS (NUM_SLOTS),
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W)
  ) u_prio (
    .fire_i  (fire),
    .tgt_i   (slot_tgt_i),
    .taken_o (taken_d),
    .idx_o   (idx_d),
    .tgt_o   (tgt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o    <= 1'b0;
      win_slot_o <= '0;
      tgt_o      <= '0;
      illegal_o  <= 1'b0;
    end else begin
      taken_o    <= taken_d;
      win_slot_o <= idx_d;
      tgt_o      <= tgt_d;
      illegal_o  <= |bad;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (!taken_o && !illegal_o)) else $error("reset"); // R1

  AST_IDLE_FALLTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !taken_o |-> (win_slot_o == '0 && tgt_o == '0)) else $error("idle"); // R8

  AST_TOP_SLOT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_vld_i[NUM_SLOTS-1] && (slot_uncond_i[NUM_SLOTS-1] || slot_pred_i[NUM_SLOTS-1]))
    |=> (taken_o && win_slot_o == IDX_W'(NUM_SLOTS-1))) else $error("top"); // R4

  AST_SLOT0_FALLBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_vld_i == NUM_SLOTS'(1) && slot_uncond_i[0])
    |=> (taken_o && win_slot_o == '0 && tgt_o == $past(slot_tgt_i[ADDR_W-1:0])))
    else $error("fallback"); // R5

  AST_ILLEGAL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|((slot_vld_i & slot_uncond_i) >> 1)) |=> illegal_o) else $error("illegal"); // R6

  AST_NOTHING_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_vld_i == '0) |=> (!taken_o && !illegal_o)) else $error("none"); // R7

endmodule

// File: tb/branch_winner_bench.sv
`timescale 1ns/1ps
module branch_winner_bench;
  localparam int N  = 4;
  localparam int W  = 32;
  localparam int IW = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   vld = '0, unc = '0, pred = '0;
  logic [N*W-1:0] tgt = '0;
  logic           taken_o, illegal_o;
  logic [IW-1:0]  win_o;
  logic [W-1:0]   tgt_o;

  int n_run = 0;
  int n_fail = 0;

  typedef struct {
    logic          taken;
    logic [IW-1:0] idx;
    logic [W-1:0]  tgt;
    logic          ill;
    string         req;
  } exp_t;

  exp_t q[$];

  always #5 clk = ~clk;

  branch_winner #(.NUM_SLOTS(N), .ADDR_W(W)) u_branch_winner (
    .clk_i(clk), .rst_ni(rst_n),
    .slot_vld_i(vld), .slot_uncond_i(unc), .slot_pred_i(pred), .slot_tgt_i(tgt),
    .taken_o(taken_o), .win_slot_o(win_o), .tgt_o(tgt_o), .illegal_o(illegal_o)
  );

  function automatic exp_t model(input logic [N-1:0] v, u, p,
                                 input logic [N*W-1:0] t, input string r);
    exp_t e;
    e.taken = 1'b0; e.idx = '0; e.tgt = '0; e.ill = 1'b0; e.req = r;
    for (int i = N - 1; i >= 0; i--) begin
      if (!e.taken && v[i] && (u[i] || p[i])) begin
        e.taken = 1'b1; e.idx = IW'(i); e.tgt = t[i*W +: W];
      end
      if (i > 0 && v[i] && u[i]) e.ill = 1'b1;
    end
    return e;
  endfunction

  task automatic drive(input logic [N-1:0] v, u, p,
                       input logic [N*W-1:0] t, input string r);
    @(negedge clk);
    vld = v; unc = u; pred = p; tgt = t;
    q.push_back(model(v, u, p, t, r));
  endtask

  function automatic logic [N*W-1:0] mk_tgt(input int seed);
    logic [N*W-1:0] t;
    for (int i = 0; i < N; i++) t[i*W +: W] = W'(32'h1000_0000 + seed * 16 + i * 4);
    return t;
  endfunction

  // monitor: outputs are due one edge after the driving negedge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (taken_o !== e.taken || win_o !== e.idx || tgt_o !== e.tgt || illegal_o !== e.ill) begin
          n_fail++;
          $display("FAIL %s: got taken=%0b idx=%0d tgt=%h ill=%0b exp taken=%0b idx=%0d tgt=%h ill=%0b",
                   e.req, taken_o, win_o, tgt_o, illegal_o, e.taken, e.idx, e.tgt, e.ill);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    n_run++; n_fail++;
    $display("FAIL watchdog: got hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    vld = 4'b1111; unc = 4'b0001; pred = 4'b1111; tgt = mk_tgt(99);
    repeat (3) @(posedge clk);
    #1;
    n_run++;
    if (taken_o !== 1'b0 || win_o !== '0 || tgt_o !== '0 || illegal_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: got taken=%0b idx=%0d tgt=%h ill=%0b expected all zero",
               taken_o, win_o, tgt_o, illegal_o);
    end
    @(negedge clk);
    vld = '0; unc = '0; pred = '0;
    rst_n = 1'b1;

    drive(4'b1111, 4'b0000, 4'b0000, mk_tgt(1), "R2");    // all cond false
    drive(4'b0100, 4'b0000, 4'b0100, mk_tgt(2), "R3");    // single cond true
    drive(4'b1010, 4'b0000, 4'b1010, mk_tgt(3), "R4");    // slot 3 beats slot 1
    drive(4'b0111, 4'b0000, 4'b0011, mk_tgt(4), "R4");    // slot 2 false, slot 1 wins
    drive(4'b0001, 4'b0001, 4'b0000, mk_tgt(5), "R5");    // slot0 uncond alone
    drive(4'b0011, 4'b0001, 4'b0010, mk_tgt(6), "R5");    // slot1 beats slot0 uncond
    drive(4'b0101, 4'b0001, 4'b0000, mk_tgt(7), "R5");    // slot2 false, slot0 fallback
    drive(4'b0101, 4'b0100, 4'b0000, mk_tgt(8), "R6");    // uncond in slot 2
    drive(4'b1001, 4'b1001, 4'b0000, mk_tgt(9), "R6");    // uncond slot3 and slot0
    drive(4'b0000, 4'b1111, 4'b1111, mk_tgt(10), "R7");   // nothing valid
    drive(4'b0001, 4'b1110, 4'b1110, mk_tgt(11), "R7");   // invalid upper slots, slot0 cond false
    drive(4'b0000, 4'b0000, 4'b0000, mk_tgt(12), "R8");
    drive(4'b1000, 4'b0000, 4'b1000, mk_tgt(13), "R9");   // back-to-back items
    drive(4'b0010, 4'b0000, 4'b0010, mk_tgt(14), "R9");
    drive(4'b0000, 4'b0000, 4'b0000, mk_tgt(15), "R9");

    for (int k = 0; k < 300; k++) begin
      logic [N-1:0]   v, u, p;
      logic [N*W-1:0] t;
      v = N'($urandom);
      p = N'($urandom);
      u = N'($urandom) & N'($urandom) & N'($urandom);
      for (int i = 0; i < N; i++) t[i*W +: W] = $urandom;
      drive(v, u, p, t, "R4");
    end

    @(negedge clk);
    vld = '0; unc = '0; pred = '0;
    repeat (3) @(posedge clk);
    #2;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule